// File: doc/BRIEF.md
# Preset-and-Detect Programmable Divider

This block divides its input clock by a programmable integer. A down-counter is loaded with a start value, steps down by one on every clock edge, and a match detector watches for a programmable stop value. On the edge that follows a match, the counter reloads the start value, so the pattern repeats with a period of (start − stop + 1) input cycles. During the match cycle the block raises a pulse one input clock wide, which serves as the divided clock.

The start and stop values are taken from the inputs only when the counter reloads. A ratio can therefore be changed at any moment without producing a shortened or stretched period. A start value below the stop value is an illegal setting. The block flags it, stops pulsing, and re-reads its inputs on every edge until a legal pair shows up.

Top module: `prog_divider`

## Requirements
- R1: While `rst` is high, and for the first cycle after the last reset edge, `count_o` equals the value present on `preset_i` at that edge and `tick_o` is low.
- R2: With a legal active setting and `count_o` different from the active stop value, each clock edge lowers `count_o` by exactly one. `count_o` never leaves the range from the active stop value to the active start value.
- R3: On the edge after a cycle in which `count_o` equals the active stop value, `count_o` takes the value present on `preset_i` at that edge, and `final_i` at that edge becomes the new active stop value.
- R4: Apart from the first cycle after reset, `tick_o` is high in exactly those cycles in which the setting is legal and `count_o` equals the active stop value.
- R5: With start P and stop F (P ≥ F), `tick_o` pulses every P − F + 1 cycles. For example, P = 7 and F = 0 gives a period of 8, covering the states 7 down to 0.
- R6: Changes to `preset_i` and `final_i` between reloads have no effect on the count sequence until the next reload.
- R7: If the active start value is less than the active stop value, `cfg_err_o` is high and `tick_o` is low. Every edge then reloads both values and the counter from the inputs, and `cfg_err_o` falls in the cycle after a legal pair is loaded.
- R8: With start equal to stop, `tick_o` is high in every cycle after the first post-reset cycle, which gives division by one. This also holds at the top code, start = stop = 255.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous reset, active high |
| preset_i | input | CNT_W | Start value, sampled at reset and at reload |
| final_i | input | CNT_W | Stop value, sampled at reset and at reload |
| count_o | output | CNT_W | Current counter state |
| tick_o | output | 1 | Divided output: one-cycle pulse in the match cycle |
| cfg_err_o | output | 1 | Active setting is illegal (start below stop) |

## Verification
The in-RTL assertions check on every cycle that:
- the counter either reloads the sampled start value or steps down by one;
- the active setting holds still between reloads;
- the count stays inside its legal window;
- a pulse never appears with an illegal setting, and each pulse is followed by a reload.

The actual division period for a given pair cannot be seen by any single-cycle property. Only the bench's scenarios show it: the modulus-8 case, an offset window, ratio one at the top code, and the full 256-state range. The same holds for the absence of a truncated period when the inputs change mid-count, and for recovery from an illegal setting. The bench's scoreboard compares every cycle of these scenarios against a model built from the requirements.

// File: rtl/pdiv_pkg.sv
`timescale 1ns/1ps
package pdiv_pkg;

   // Why the counter is being (re)loaded in a given cycle.
   typedef enum logic [1:0] {
      LD_NONE     = 2'd0,
      LD_RESET    = 2'd1,
      LD_TERMINAL = 2'd2,
      LD_RECOVER  = 2'd3
   } load_cause_e;

   function automatic logic is_load(input load_cause_e cause);
      return cause != LD_NONE;
   endfunction

endpackage

// File: rtl/pdiv_cfg_hold.sv
`timescale 1ns/1ps
// Active start/stop registers; captured only on a load.
module pdiv_cfg_hold #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load,
   input  logic [W-1:0] start_in,
   input  logic [W-1:0] stop_in,
   output logic [W-1:0] start_q,
   output logic [W-1:0] stop_q,
   output logic         bad_o
);

   initial assert (W >= 2) else $error("pdiv_cfg_hold: W must be at least 2");

   always_ff @(posedge clk) begin
      if (load) begin
         start_q <= start_in;
         stop_q  <= stop_in;
      end
   end

   assign bad_o = start_q < stop_q;

   // R6: the active setting moves only on a load edge
   assert_cfg_stable_R6: assert property (@(posedge clk) disable iff (rst)
      !load |=> ($stable(start_q) && $stable(stop_q)));

   // R3: a load captures exactly the input values of that edge
   assert_cfg_capture_R3: assert property (@(posedge clk) disable iff (rst)
      load |=> (start_q == $past(start_in) && stop_q == $past(stop_in)));

endmodule

// File: rtl/pdiv_match.sv
`timescale 1ns/1ps
// Terminal-state detector; STYLE picks a plain compare or a per-bit tree.
module pdiv_match #(
   parameter int W     = 8,
   parameter int STYLE = 1
) (
   input  logic [W-1:0] cur,
   input  logic [W-1:0] target,
   output logic         hit
);

   initial assert (STYLE == 0 || STYLE == 1) else $error("pdiv_match: STYLE must be 0 or 1");

   generate
      if (STYLE == 0) begin : g_cmp
         assign hit = (cur == target);
      end else begin : g_tree
         logic [W-1:0] same;
         for (genvar b = 0; b < W; b++) begin : g_bit
            assign same[b] = ~(cur[b] ^ target[b]);
         end
         assign hit = &same;
      end
   endgenerate

endmodule

// File: rtl/pdiv_downcnt.sv
`timescale 1ns/1ps
// Loadable down-counter.
module pdiv_downcnt #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic [W-1:0] count_q
);

   localparam logic [W-1:0] STEP = W'(1);

   initial assert (W >= 2) else $error("pdiv_downcnt: W must be at least 2");

   always_ff @(posedge clk) begin
      if (load) count_q <= load_val;
      else      count_q <= count_q - STEP;
   end

   // R2: without a load the state falls by exactly one
   assert_step_down_R2: assert property (@(posedge clk) disable iff (rst)
      !load |=> (count_q == $past(count_q) - STEP));

   // R3: a load places the presented value in the counter
   assert_reload_R3: assert property (@(posedge clk) disable iff (rst)
      load |=> (count_q == $past(load_val)));

endmodule

// File: rtl/prog_divider.sv
`timescale 1ns/1ps
module prog_divider
   import pdiv_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter int MATCH_STYLE = 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [CNT_W-1:0] preset_i,
   input  logic [CNT_W-1:0] final_i,
   output logic [CNT_W-1:0] count_o,
   output logic             tick_o,
   output logic             cfg_err_o
);

   initial assert (CNT_W >= 2 && CNT_W <= 32) else $error("prog_divider: CNT_W out of range");

   logic [CNT_W-1:0] start_act;
   logic [CNT_W-1:0] stop_act;
   logic             at_stop;
   logic             run_q;
   logic             do_load;
   load_cause_e      cause;

   // Reset first, then recovery from an illegal setting, then normal terminal reload.
   always_comb begin
      if (rst)            cause = LD_RESET;
      else if (cfg_err_o) cause = LD_RECOVER;
      else if (at_stop)   cause = LD_TERMINAL;
      else                cause = LD_NONE;
   end

   assign do_load = is_load(cause);

   pdiv_cfg_hold #(.W(CNT_W)) u_cfg (
      .clk      (clk),
      .rst      (rst),
      .load     (do_load),
      .start_in (preset_i),
      .stop_in  (final_i),
      .start_q  (start_act),
      .stop_q   (stop_act),
      .bad_o    (cfg_err_o)
   );

   pdiv_downcnt #(.W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst      (rst),
      .load     (do_load),
      .load_val (preset_i),
      .count_q  (count_o)
   );

   pdiv_match #(.W(CNT_W), .STYLE(MATCH_STYLE)) u_eoc (
      .cur    (count_o),
      .target (stop_act),
      .hit    (at_stop)
   );

   // Masks the pulse in the first cycle after reset.
   always_ff @(posedge clk) begin
      if (rst) run_q <= 1'b0;
      else     run_q <= 1'b1;
   end

   assign tick_o = run_q & at_stop & ~cfg_err_o;

   // R7: no pulse with an illegal setting
   assert_no_tick_on_err_R7: assert property (@(posedge clk) disable iff (rst)
      cfg_err_o |-> !tick_o);

   // R3: every pulse is followed by a reload from the start input
   assert_tick_reload_R3: assert property (@(posedge clk) disable iff (rst)
      tick_o |=> (count_o == $past(preset_i)));

   // R2: with a legal setting the count stays inside its window
   assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
      !cfg_err_o |-> (count_o >= stop_act && count_o <= start_act));

   // R1: first cycle after reset never pulses
   assert_reset_quiet_R1: assert property (@(posedge clk)
      rst |=> !tick_o);

endmodule

// File: tb/tb_prog_divider.sv
`timescale 1ns/1ps
module tb_prog_divider;

   localparam int W = 8;

   typedef struct packed {
      logic [W-1:0] cnt;
      logic         tick;
      logic         err;
   } exp_t;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [W-1:0] preset_i = '0;
   logic [W-1:0] final_i  = '0;
   logic [W-1:0] count_o;
   logic         tick_o;
   logic         cfg_err_o;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   exp_t  exp_q[$];
   string tag_q[$];

   // reference model state
   logic [W-1:0] m_cnt = '0, m_p = '0, m_f = '0;
   bit           m_run = 1'b0;

   // tick spacing measured at the ports
   int cyc_n    = 0;
   int last_tk  = -1;
   int last_gap = 0;

   always #4 clk = ~clk;

   prog_divider #(.CNT_W(W)) dut (
      .clk       (clk),
      .rst       (rst),
      .preset_i  (preset_i),
      .final_i   (final_i),
      .count_o   (count_o),
      .tick_o    (tick_o),
      .cfg_err_o (cfg_err_o)
   );

   task automatic chk(input bit ok, input string what, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
      end
   endtask

   task automatic model_edge(input logic [W-1:0] p, input logic [W-1:0] f, input logic r);
      if (r) begin
         m_cnt = p; m_p = p; m_f = f; m_run = 1'b0;
      end else begin
         m_run = 1'b1;
         if ((m_p < m_f) || (m_cnt == m_f)) begin
            m_cnt = p; m_p = p; m_f = f;
         end else begin
            m_cnt = m_cnt - 1'b1;
         end
      end
   endtask

   // driver: apply inputs, advance model at the edge, push expected outputs
   task automatic drive(input logic [W-1:0] p, input logic [W-1:0] f, input logic r,
                        input int n, input string tag);
      exp_t e;
      for (int i = 0; i < n; i++) begin
         preset_i = p; final_i = f; rst = r;
         @(posedge clk);
         model_edge(p, f, r);
         #1;
         e.cnt  = m_cnt;
         e.err  = (m_p < m_f);
         e.tick = m_run && !(m_p < m_f) && (m_cnt == m_f);
         exp_q.push_back(e);
         tag_q.push_back(tag);
      end
   endtask

   // monitor: pop and compare away from the active edge
   always @(negedge clk) begin
      exp_t  e;
      string t;
      cyc_n++;
      if (tick_o === 1'b1) begin
         if (last_tk >= 0) last_gap = cyc_n - last_tk;
         last_tk = cyc_n;
      end
      if (exp_q.size() > 0) begin
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         chk(count_o === e.cnt, {t, " count_o"}, int'(count_o), int'(e.cnt));
         chk(tick_o === e.tick, {t, " tick_o"}, int'(tick_o), int'(e.tick));
         chk(cfg_err_o === e.err, {t, " cfg_err_o"}, int'(cfg_err_o), int'(e.err));
      end
   end

   initial begin
      // R1: reset with modulus-8 setting
      drive(8'd7, 8'd0, 1'b1, 3, "R1 reset");
      @(negedge clk);
      chk(count_o == 8'd7 && tick_o == 1'b0, "R1 reset state", int'(count_o), 7);
      drive(8'd7, 8'd0, 1'b0, 1, "R1 first cycle");
      drive(8'd7, 8'd0, 1'b0, 30, "R2 R3 R4 mod8");
      chk(last_gap == 8, "R5 mod8 period", last_gap, 8);

      // R5: offset window 12..5
      drive(8'd12, 8'd5, 1'b1, 2, "R1 reset2");
      drive(8'd12, 8'd5, 1'b0, 4, "R4 offset");
      // R6: inputs change mid-count; current period must complete
      drive(8'd3, 8'd1, 1'b0, 6, "R6 midcount change");
      drive(8'd3, 8'd1, 1'b0, 14, "R6 new ratio");
      chk(last_gap == 3, "R6 new period", last_gap, 3);

      // offset period directly, no intervening change
      drive(8'd12, 8'd5, 1'b0, 30, "R5 offset run");
      chk(last_gap == 8, "R5 offset period", last_gap, 8);

      // R8: ratio one at mid and top codes
      drive(8'd9, 8'd9, 1'b0, 20, "R8 ratio one");
      chk(last_gap == 1, "R8 period mid", last_gap, 1);
      drive(8'd255, 8'd255, 1'b0, 20, "R8 top code");
      chk(last_gap == 1, "R8 period top", last_gap, 1);

      // R7: illegal pair, then recovery
      drive(8'd2, 8'd6, 1'b0, 6, "R7 illegal");
      @(negedge clk);
      chk(cfg_err_o == 1'b1 && tick_o == 1'b0, "R7 flag raised", int'(cfg_err_o), 1);
      drive(8'd4, 8'd2, 1'b0, 12, "R7 recovery");
      chk(cfg_err_o == 1'b0 && last_gap == 3, "R7 recovered period", last_gap, 3);

      // R7: illegal setting straight out of reset
      drive(8'd1, 8'd3, 1'b1, 2, "R1 reset3");
      drive(8'd1, 8'd3, 1'b0, 4, "R7 illegal after reset");
      drive(8'd255, 8'd0, 1'b0, 600, "R5 full range");
      chk(last_gap == 256, "R5 full range period", last_gap, 256);

      // drain scoreboard
      repeat (3) @(negedge clk);
      chk(exp_q.size() == 0, "R4 scoreboard drained", exp_q.size(), 0);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
         $finish;
      end
   end

endmodule